// File: doc/BRIEF.md
# Delete-State Column Max-Prefix Engine

This block computes the delete-state score vector of one profile column. The serial form is D[0] = A[0] and D[j] = max(D[j-1] + B[j], A[j]) for j ≥ 1. That chain is N additions deep, so the block evaluates it in logarithmic depth instead. The running sum B' of the transition vector B is formed once, when B is loaded. Each column then subtracts B' from A element by element, takes a max-prefix over the differences in a Brent-Kung network, adds B' back and keeps the larger of that result and A. The differences and sums live in a widened signed word and cannot wrap. Only the final value is brought back to 16 bits.

The block accepts one column per clock and registers every prefix level. For large N the vector can be split into P tiles. Each tile runs its own N/P-wide network, and one extra stage folds the tile maxima together. A caller loads B once per profile and then streams A vectors. Every result comes out with a valid strobe after a fixed latency.

Top module: `dcol_maxscan`

## Requirements
- R1: After reset, d_valid_o is low. Until the first load, B is taken as all zeros, so D is the running maximum of A.
- R2: Score words are 16-bit two's complement, and element j sits at bits [16j+15:16j] of every vector port. For each accepted column, D matches the serial recurrence D[0] = A[0], D[j] = max(D[j-1] + B[j], A[j]) bit-exactly. All intermediate sums are exact and never saturate or wrap. Only the final value is clamped as R5 states.
- R3: Element 0 of B has no effect on any output.
- R4: The code -32768 in A means minus infinity. Such an element never wins a max, and adding anything to minus infinity gives minus infinity. When A[0..j] are all minus infinity, D[j] is -32768.
- R5: A final value above 32767 is output as 32767. A final value below -32767 is output as -32768 (minus infinity). The code -32768 in B is an ordinary finite number.
- R6: A column accepted on a rising edge with col_valid_i high yields d_valid_o high for exactly one cycle. That cycle begins LAT cycles after the accepting edge. LAT is 2·log2(N/P) − 2 when P = 1 and 2·log2(N/P) − 1 when P > 1. Back-to-back columns give back-to-back results, and d_valid_o is never high otherwise.
- R7: A B vector loaded with b_load_i is used only by columns accepted on later edges. A column accepted on the same edge as the load, and every column already in flight, uses the previous B.
- R8: With P > 1 tiles, the outputs are identical to those of the untiled block for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| b_load_i | input | 1 | Capture b_vec_i and form its running sum |
| b_vec_i | input | N·16 | Transition vector B, element 0 unused |
| col_valid_i | input | 1 | Accept a_vec_i as a new column |
| a_vec_i | input | N·16 | Candidate vector A of the column |
| d_valid_o | output | 1 | d_vec_o holds a result this cycle |
| d_vec_o | output | N·16 | Delete-state vector D |

## Verification
A B load and a column acceptance can fall on the same clock edge. The bench drives both together, and also loads a new B while earlier columns are still in the prefix pipeline. A serial reference model in the bench computes each column's expected vector at its acceptance edge from the B held before that edge, and updates its own B afterwards. It compares every cycle's strobe and data, for an untiled and a two-tile instance side by side. Any leakage of a new B into a column that should use the old one therefore shows up as a data mismatch in the cycle the result is due.

// File: rtl/dcol_pkg.sv
package dcol_pkg;
  localparam int unsigned SCORE_W = 16;
  typedef logic signed [SCORE_W-1:0] score_t;
  localparam score_t SCORE_NEG_INF = {1'b1, {(SCORE_W-1){1'b0}}};
  localparam score_t SCORE_POS_MAX = {1'b0, {(SCORE_W-1){1'b1}}};
endpackage

// File: rtl/dcol_bsum.sv
module dcol_bsum
  import dcol_pkg::*;
#(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned WW     = SCORE_W + 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [N_ELEM*SCORE_W-1:0]   b_vec_i,
  output logic signed [WW-1:0]        psum_o [N_ELEM]
);
  typedef logic signed [WW-1:0] wide_t;

  wide_t run [N_ELEM];

  // ripple chain: evaluated once per profile load, off the column path
  always_comb begin
    wide_t acc;
    acc    = '0;
    run[0] = '0;
    for (int j = 1; j < int'(N_ELEM); j++) begin
      acc    = acc + wide_t'(score_t'(b_vec_i[j*SCORE_W +: SCORE_W]));
      run[j] = acc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < int'(N_ELEM); j++) psum_o[j] <= '0;
    end else if (load_i) begin
      for (int j = 0; j < int'(N_ELEM); j++) psum_o[j] <= run[j];
    end
  end

  wide_t b1_ext;
  assign b1_ext = wide_t'(score_t'(b_vec_i[SCORE_W +: SCORE_W]));

  // R7, R3: after a load the base term is zero and the first term is B[1]
  a_r7_bsum_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (psum_o[0] == '0) && (psum_o[1] == $past(b1_ext)));

  // R7: running sum is held between loads
  a_r7_bsum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(psum_o[N_ELEM-1]));
endmodule

// File: rtl/dcol_bk_prefix.sv
module dcol_bk_prefix #(
  parameter int unsigned NT = 8,
  parameter int unsigned WW = 21
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [WW-1:0] x_i [NT],
  output logic signed [WW-1:0] y_o [NT]
);
  localparam int unsigned LG = $clog2(NT);
  localparam int unsigned LV = 2 * LG - 1;

  typedef logic signed [WW-1:0] wide_t;

  wide_t stg [LV+1][NT];

  for (genvar i = 0; i < NT; i++) begin : g_in
    assign stg[0][i] = x_i[i];
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam bit UP = (l < LG);
    // up-sweep spans double; down-sweep spans halve back
    localparam int DIST = UP ? (1 << l) : (1 << (2 * LG - 2 - l));
    wide_t nxt [NT];

    for (genvar i = 0; i < NT; i++) begin : g_el
      localparam bit ACT = UP ? (((i + 1) % (2 * DIST)) == 0)
                              : ((((i + 1) % (2 * DIST)) == DIST) && (i >= 2 * DIST));
      if (ACT) begin : g_op
        assign nxt[i] = (stg[l][i-DIST] > stg[l][i]) ? stg[l][i-DIST] : stg[l][i];
      end else begin : g_pass
        assign nxt[i] = stg[l][i];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(NT); i++) stg[l+1][i] <= '0;
      end else begin
        for (int i = 0; i < int'(NT); i++) stg[l+1][i] <= nxt[i];
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_out
    assign y_o[i] = stg[LV][i];
  end

  // R2: a completed max-prefix never decreases along the vector
  for (genvar i = 1; i < NT; i++) begin : g_chk
    a_r2_prefix_monotone: assert property (@(posedge clk_i) disable iff (!rst_ni)
      y_o[i] >= y_o[i-1]);
  end
endmodule

// File: rtl/dcol_maxscan.sv
module dcol_maxscan
  import dcol_pkg::*;
#(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned TILES  = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      b_load_i,
  input  logic [N_ELEM*SCORE_W-1:0] b_vec_i,
  input  logic                      col_valid_i,
  input  logic [N_ELEM*SCORE_W-1:0] a_vec_i,
  output logic                      d_valid_o,
  output logic [N_ELEM*SCORE_W-1:0] d_vec_o
);
  localparam int unsigned SW     = SCORE_W;
  localparam int unsigned LGN    = $clog2(N_ELEM);
  localparam int unsigned WW     = SW + LGN + 2;
  localparam int unsigned NT     = N_ELEM / TILES;
  localparam int unsigned LGT    = $clog2(NT);
  localparam int unsigned BK_LV  = 2 * LGT - 1;
  localparam int unsigned MERGE  = (TILES > 1) ? 1 : 0;
  localparam int unsigned STAGES = BK_LV + MERGE;
  localparam int unsigned LAT    = STAGES - 1;
  localparam int unsigned CW     = $clog2(LAT + 3) + 1;

  typedef logic signed [WW-1:0] wide_t;
  localparam wide_t W_NEG   = {1'b1, {(WW-1){1'b0}}};
  localparam wide_t W_POS   = wide_t'(SCORE_POS_MAX);
  localparam wide_t W_FLOOR = -W_POS;

  function automatic wide_t widen(input score_t s);
    return (s == SCORE_NEG_INF) ? W_NEG : wide_t'(s);
  endfunction

  function automatic wide_t wmax(input wide_t x, input wide_t y);
    return (x > y) ? x : y;
  endfunction

  score_t a_el [N_ELEM];
  wide_t  psum [N_ELEM];
  wide_t  c_w  [N_ELEM];
  wide_t  pre  [N_ELEM];
  wide_t  scan [N_ELEM];

  dcol_bsum #(.N_ELEM(N_ELEM), .WW(WW)) u_bsum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (b_load_i),
    .b_vec_i(b_vec_i),
    .psum_o (psum)
  );

  for (genvar j = 0; j < N_ELEM; j++) begin : g_diff
    assign a_el[j] = score_t'(a_vec_i[j*SW +: SW]);
    // minus infinity bypasses the subtraction
    assign c_w[j]  = (a_el[j] == SCORE_NEG_INF) ? W_NEG : widen(a_el[j]) - psum[j];
  end

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    wide_t t_in  [NT];
    wide_t t_out [NT];
    for (genvar i = 0; i < NT; i++) begin : g_map
      assign t_in[i]       = c_w[t*NT + i];
      assign pre[t*NT + i] = t_out[i];
    end
    dcol_bk_prefix #(.NT(NT), .WW(WW)) u_bk (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .x_i   (t_in),
      .y_o   (t_out)
    );
  end

  if (MERGE != 0) begin : g_merge
    wide_t mrg [N_ELEM];
    // ripple over tile maxima: TILES-1 comparators deep
    always_comb begin
      wide_t run;
      run = W_NEG;
      for (int t = 0; t < int'(TILES); t++) begin
        for (int i = 0; i < int'(NT); i++) mrg[t*NT + i] = wmax(pre[t*NT + i], run);
        run = wmax(run, pre[t*NT + NT - 1]);
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < int'(N_ELEM); j++) scan[j] <= '0;
      end else begin
        for (int j = 0; j < int'(N_ELEM); j++) scan[j] <= mrg[j];
      end
    end
  end else begin : g_nomerge
    for (genvar j = 0; j < N_ELEM; j++) begin : g_pass
      assign scan[j] = pre[j];
    end
  end

  // sideband: A and B' travel with their column for the add-back and compare
  score_t            sb_a [STAGES][N_ELEM];
  wide_t             sb_p [STAGES][N_ELEM];
  logic [STAGES-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < int'(STAGES); s++) begin
        for (int j = 0; j < int'(N_ELEM); j++) begin
          sb_a[s][j] <= '0;
          sb_p[s][j] <= '0;
        end
      end
    end else begin
      vld_q[0] <= col_valid_i;
      for (int j = 0; j < int'(N_ELEM); j++) begin
        sb_a[0][j] <= a_el[j];
        sb_p[0][j] <= psum[j];
      end
      for (int s = 1; s < int'(STAGES); s++) begin
        vld_q[s] <= vld_q[s-1];
        for (int j = 0; j < int'(N_ELEM); j++) begin
          sb_a[s][j] <= sb_a[s-1][j];
          sb_p[s][j] <= sb_p[s-1][j];
        end
      end
    end
  end

  assign d_valid_o = vld_q[STAGES-1];

  score_t d_el [N_ELEM];

  for (genvar j = 0; j < N_ELEM; j++) begin : g_out
    wide_t s_sum, a_w, best;
    assign s_sum   = (scan[j] == W_NEG) ? W_NEG : scan[j] + sb_p[STAGES-1][j];
    assign a_w     = widen(sb_a[STAGES-1][j]);
    assign best    = wmax(s_sum, a_w);
    assign d_el[j] = (best > W_POS)   ? SCORE_POS_MAX :
                     (best < W_FLOOR) ? SCORE_NEG_INF : score_t'(best[SW-1:0]);
    assign d_vec_o[j*SW +: SW] = d_el[j];

    // R2: the result never falls below the column's own candidate
    a_r2_not_below_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
      d_valid_o |-> (d_el[j] >= sb_a[STAGES-1][j]));
  end

  // in-flight count for the strobe checks
  logic [CW-1:0] inflight_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CW'(col_valid_i) - CW'(d_valid_o);
  end

  // R6: a strobe always belongs to an accepted column
  a_r6_valid_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o |-> (inflight_q != '0));

  // R6: no column is held longer than the pipeline depth
  a_r6_inflight_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inflight_q <= CW'(LAT + 1));

  // R2: the first element is the first candidate
  a_r2_head_equals_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_valid_o |-> (d_el[0] == sb_a[STAGES-1][0]));
endmodule

// File: tb/dcol_maxscan_bench.sv
`timescale 1ns/1ps
module dcol_maxscan_bench;
  localparam int N    = 8;
  localparam int SW   = 16;
  localparam int VW   = N * SW;
  localparam int LAT0 = 2 * $clog2(N) - 2;
  localparam int LAT1 = 2 * $clog2(N / 2) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic b_load_i = 1'b0;
  logic col_valid_i = 1'b0;
  logic [VW-1:0] b_vec_i = '0;
  logic [VW-1:0] a_vec_i = '0;
  logic d_valid0, d_valid1;
  logic [VW-1:0] d_vec0, d_vec1;

  always #4 clk_i = ~clk_i;

  dcol_maxscan #(.N_ELEM(N), .TILES(1)) u_dcol_maxscan (
    .clk_i(clk_i), .rst_ni(rst_ni), .b_load_i(b_load_i), .b_vec_i(b_vec_i),
    .col_valid_i(col_valid_i), .a_vec_i(a_vec_i), .d_valid_o(d_valid0), .d_vec_o(d_vec0));

  dcol_maxscan #(.N_ELEM(N), .TILES(2)) u_dcol_maxscan_tiled (
    .clk_i(clk_i), .rst_ni(rst_ni), .b_load_i(b_load_i), .b_vec_i(b_vec_i),
    .col_valid_i(col_valid_i), .a_vec_i(a_vec_i), .d_valid_o(d_valid1), .d_vec_o(d_vec1));

  typedef struct { int due; logic [VW-1:0] d; string tag; } exp_t;
  exp_t q0[$];
  exp_t q1[$];
  logic [VW-1:0] b_model = '0;
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  function automatic logic [VW-1:0] ref_col(input logic [VW-1:0] av, input logic [VW-1:0] bv);
    longint sent, d, cand, aj, bj;
    logic [VW-1:0] r;
    sent = -(64'sd1 <<< 40);
    d = sent;
    for (int j = 0; j < N; j++) begin
      aj = longint'($signed(av[j*SW +: SW]));
      if (aj == -32768) aj = sent;
      bj = longint'($signed(bv[j*SW +: SW]));
      if (j == 0) d = aj;
      else begin
        cand = (d == sent) ? sent : d + bj;
        d = (cand > aj) ? cand : aj;
      end
      if (d > 32767)       r[j*SW +: SW] = 16'h7fff;
      else if (d < -32767) r[j*SW +: SW] = 16'h8000;
      else                 r[j*SW +: SW] = d[15:0];
    end
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (rst_ni) begin
      exp_t e;
      cyc = cyc + 1;
      if (col_valid_i) begin
        e.d = ref_col(a_vec_i, b_model);
        e.tag = cur_tag;
        e.due = cyc + LAT0;
        q0.push_back(e);
        e.due = cyc + LAT1;
        q1.push_back(e);
      end
      if (b_load_i) b_model = b_vec_i;
    end
  end

  task automatic judge(input int idx, input logic v, input logic [VW-1:0] d);
    exp_t e;
    logic have;
    have = 1'b0;
    if (idx == 0) begin
      if (q0.size() > 0 && q0[0].due <= cyc) begin e = q0.pop_front(); have = 1'b1; end
    end else begin
      if (q1.size() > 0 && q1[0].due <= cyc) begin e = q1.pop_front(); have = 1'b1; end
    end
    checks++;
    if (have) begin
      if (v !== 1'b1 || e.due != cyc) begin
        errors++;
        $display("FAIL R6 dut%0d strobe act=%b exp=1 due=%0d cyc=%0d", idx, v, e.due, cyc);
      end
      checks++;
      if (d !== e.d) begin
        errors++;
        $display("FAIL %s%s dut%0d data act=%h exp=%h", (idx == 1) ? "R8 " : "", e.tag, idx, d, e.d);
      end
    end else if (v !== 1'b0) begin
      errors++;
      $display("FAIL R6 dut%0d stray strobe act=%b exp=0 cyc=%0d", idx, v, cyc);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      judge(0, d_valid0, d_vec0);
      judge(1, d_valid1, d_vec1);
    end
  end

  task automatic step(input logic v, input logic [VW-1:0] a, input logic ld,
                      input logic [VW-1:0] b, input string t);
    @(negedge clk_i);
    col_valid_i = v;
    a_vec_i = a;
    b_load_i = ld;
    if (ld) b_vec_i = b;
    cur_tag = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, "idle");
  endtask

  function automatic logic [VW-1:0] fill(input logic [SW-1:0] x);
    logic [VW-1:0] r;
    for (int j = 0; j < N; j++) r[j*SW +: SW] = x;
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_a();
    logic [VW-1:0] r;
    for (int j = 0; j < N; j++) begin
      if ($urandom_range(7) == 0) r[j*SW +: SW] = 16'h8000;
      else r[j*SW +: SW] = 16'($signed(int'($urandom_range(4000)) - 2000));
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_b(input int span);
    logic [VW-1:0] r;
    for (int j = 0; j < N; j++)
      r[j*SW +: SW] = 16'($signed(int'($urandom_range(2 * span)) - span));
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired cyc=%0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b;
    repeat (3) @(negedge clk_i);
    checks++;
    if (d_valid0 !== 1'b0 || d_valid1 !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid during reset act=%b%b exp=00", d_valid0, d_valid1);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (d_valid0 !== 1'b0 || d_valid1 !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid after reset act=%b%b exp=00", d_valid0, d_valid1);
    end

    // R1: B is zero before any load, D is the running max of A
    for (int i = 0; i < 4; i++) step(1'b1, rand_a(), 1'b0, '0, "R1");
    idle(6);

    // R2: general columns under a finite B
    step(1'b0, '0, 1'b1, rand_b(300), "R2");
    for (int i = 0; i < 6; i++) step(1'b1, rand_a(), 1'b0, '0, "R2");
    idle(6);

    // R2: exact intermediates: dips far below the floor, then recovers
    b = fill(16'd0);
    b[1*SW +: SW] = 16'($signed(-20000));
    b[2*SW +: SW] = 16'($signed(-20000));
    b[3*SW +: SW] = 16'd30000;
    b[4*SW +: SW] = 16'd15000;
    a = fill(16'h8000);
    a[0 +: SW] = 16'($signed(-10000));
    step(1'b0, '0, 1'b1, b, "R2");
    step(1'b1, a, 1'b0, '0, "R2");

    // R3: two loads differing only in B[0]
    b = rand_b(200);
    b[0 +: SW] = 16'h7fff;
    a = rand_a();
    step(1'b1, a, 1'b1, b, "R3");
    step(1'b1, a, 1'b0, '0, "R3");
    b[0 +: SW] = 16'h8000;
    step(1'b1, a, 1'b1, b, "R3");
    step(1'b1, a, 1'b0, '0, "R3");
    idle(6);

    // R4: minus infinity patterns
    step(1'b0, '0, 1'b1, fill(16'd1), "R4");
    step(1'b1, fill(16'h8000), 1'b0, '0, "R4");
    a = fill(16'h8000);
    a[2*SW +: SW] = 16'd5;
    step(1'b1, a, 1'b0, '0, "R4");
    a = fill(16'h8000);
    a[(N-1)*SW +: SW] = 16'($signed(-7));
    step(1'b1, a, 1'b0, '0, "R4");
    idle(6);

    // R5: clamp at both ends, B code -32768 taken as a number
    step(1'b0, '0, 1'b1, fill(16'h7fff), "R5");
    a = fill(16'h8000);
    a[0 +: SW] = 16'h7fff;
    step(1'b1, a, 1'b0, '0, "R5");
    step(1'b0, '0, 1'b1, fill(16'h8000), "R5");
    a = fill(16'h8000);
    a[0 +: SW] = 16'($signed(-100));
    step(1'b1, a, 1'b0, '0, "R5");
    step(1'b1, fill(16'h7fff), 1'b0, '0, "R5");
    idle(6);

    // R7: load on the same edge as a column, and loads while columns are in flight
    step(1'b0, '0, 1'b1, rand_b(100), "R7");
    step(1'b1, rand_a(), 1'b1, rand_b(400), "R7");
    step(1'b1, rand_a(), 1'b0, '0, "R7");
    step(1'b0, '0, 1'b1, rand_b(50), "R7");
    step(1'b1, rand_a(), 1'b1, rand_b(250), "R7");
    step(1'b1, rand_a(), 1'b1, rand_b(250), "R7");
    step(1'b1, rand_a(), 1'b0, '0, "R7");
    idle(6);

    // R6: dense random stream with sporadic loads
    for (int i = 0; i < 600; i++)
      step($urandom_range(3) != 0, rand_a(), $urandom_range(9) == 0,
           rand_b(($urandom_range(1) != 0) ? 2000 : 60), "R6");
    idle(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule